// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two IEEE-754 values and returns a four-bit condition result, arranged as negative, zero, carry and overflow (NZCV). Each compare is also folded into a 32-bit status word that the unit keeps. One input picks the operand width: single precision uses the low 32 bits of each operand bus, and double precision uses all 64 bits. A second input picks quiet or signalling behaviour for NaNs. A third input replaces the second operand with positive zero, so a value can be tested against zero without loading a zero operand.

The unit never unpacks or rounds its operands. Ordering comes straight from the packed bit patterns. When the signs differ, the negative value is the smaller one. When the signs match, an unsigned compare of the packed words gives the order, and that order is reversed when both values are negative. The new flags replace the condition nibble of the status word. An invalid-operation bit in the status word is sticky: it stays set until reset or until software writes the status word.

Top module: `fcmp_flag_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones (bits 30:23 single, bits 62:52 double) and its mantissa field is non-zero. If either operand is a NaN, the flags are NZCV = 4'b0011 (flags[3]=N, flags[2]=Z, flags[1]=C, flags[0]=V).
- R2: A NaN whose top mantissa bit (bit 22 single, bit 51 double) is clear is signalling. With sigMode=0, only a signalling NaN raises invalid-operation. With sigMode=1, any NaN raises it. Invalid-operation sets status bit 0, and invalidOp mirrors that bit.
- R3: Equal operands give 4'b0110. Two operands whose bits other than the sign are all zero compare equal, whatever their signs.
- R4: When the signs differ, the negative operand is smaller. First below second gives 4'b1000. First above second gives 4'b0010.
- R5: When the signs match, the order comes from the unsigned compare of the packed words, reversed when both operands are negative.
- R6: With cmpZero=1, the second operand is treated as +0.0 and opB is ignored.
- R7: With isDouble=0, only opA[31:0] and opB[31:0] are used, and the upper halves have no effect.
- R8: A compare without a status write sets status[31:28] to the new NZCV, keeps status[27:1] unchanged, and ORs the invalid-operation result into status[0].
- R9: When statWrEn is high, status takes statWrData on the next edge. This write overrides a compare merge in the same cycle. It is the only way, besides reset, to clear status[0].
- R10: The flags and outValid are registered one cycle after inValid. outValid is a one-cycle pulse, and the flags hold until the next compare.
- R11: After reset, status, flags and outValid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Starts a compare this cycle |
| isDouble | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit |
| sigMode | input | 1 | 1 makes any NaN raise invalid-operation |
| cmpZero | input | 1 | 1 compares opA against +0.0 |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| statWrEn | input | 1 | Loads the status word |
| statWrData | input | 32 | Data for a status load |
| outValid | output | 1 | One-cycle pulse marking new flags |
| flags | output | 4 | Compare result {N,Z,C,V} |
| invalidOp | output | 1 | Sticky invalid-operation bit |
| status | output | 32 | Status word |

## Verification
The bench covers the following corner cases and the failure each one would expose:
- **Signed zeros.** +0 against -0 must compare equal. A design that compares raw words would report the positive zero as greater.
- **Two negative values.** A pair of negatives checks that the unsigned order is reversed. A design that skips the reversal would swap less and greater.
- **Quiet versus signalling NaN.** A quiet NaN in quiet mode must leave invalid-operation low. A signalling NaN must set it and keep it set over later clean compares. A design with a wrong mode decode or a non-sticky bit shows a wrong status[0].
- **Ignored inputs.** Junk upper halves in single mode, and a non-zero opB under compare-with-zero, must not change the result. A wrong operand select shows up directly in the flags.
- **Status word handling.** A status write in the same cycle as a compare must win. The middle status bits must survive a merge.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int STAT_W   = 32;

  localparam logic [3:0] NZCV_UNORD = 4'b0011;
  localparam logic [3:0] NZCV_EQ    = 4'b0110;
  localparam logic [3:0] NZCV_LT    = 4'b1000;
  localparam logic [3:0] NZCV_GT    = 4'b0010;

  typedef struct packed {
    logic loadFlags;
    logic mergeStat;
    logic writeStat;
  } fcmpStrobes_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = EXP_W + MAN_W + 1
) (
  input  logic [W-1:0] word,
  output logic         sign,
  output logic         isNan,
  output logic         isSnan,
  output logic         magZero
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;

  assign sign     = word[W-1];
  assign expField = word[W-2:MAN_W];
  assign manField = word[MAN_W-1:0];
  assign isNan    = (&expField) && (|manField);
  assign isSnan   = isNan && !manField[MAN_W-1];
  assign magZero  = !(|word[W-2:0]);
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         statWrEn,
  output fcmpStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.loadFlags = inValid;
    strobes.mergeStat = inValid && !statWrEn;
    strobes.writeStat = statWrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int SEXP = SP_EXP_W,
  parameter int SMAN = SP_MAN_W,
  parameter int DEXP = DP_EXP_W,
  parameter int DMAN = DP_MAN_W,
  parameter int SW   = STAT_W,
  localparam int SPW = SEXP + SMAN + 1,
  localparam int DPW = DEXP + DMAN + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fcmpStrobes_t  strobes,
  input  logic          isDouble,
  input  logic          sigMode,
  input  logic          cmpZero,
  input  logic [DPW-1:0] opA,
  input  logic [DPW-1:0] opB,
  input  logic [SW-1:0] statWrData,
  output logic [3:0]    flags,
  output logic [SW-1:0] status
);
  logic [DPW-1:0] words [2];
  logic [1:0] spSign, spNan, spSnan, spZero;
  logic [1:0] dpSign, dpNan, dpSnan, dpZero;
  logic [1:0] sgn, nan, snan, zero;

  always_comb begin
    words[0] = isDouble ? opA : {{(DPW-SPW){1'b0}}, opA[SPW-1:0]};
    if (cmpZero)       words[1] = '0;
    else if (isDouble) words[1] = opB;
    else               words[1] = {{(DPW-SPW){1'b0}}, opB[SPW-1:0]};
  end

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    fcmp_classify #(.EXP_W(SEXP), .MAN_W(SMAN)) u_sp (
      .word(words[g][SPW-1:0]), .sign(spSign[g]), .isNan(spNan[g]),
      .isSnan(spSnan[g]), .magZero(spZero[g]));
    fcmp_classify #(.EXP_W(DEXP), .MAN_W(DMAN)) u_dp (
      .word(words[g]), .sign(dpSign[g]), .isNan(dpNan[g]),
      .isSnan(dpSnan[g]), .magZero(dpZero[g]));
    assign sgn[g]  = isDouble ? dpSign[g] : spSign[g];
    assign nan[g]  = isDouble ? dpNan[g]  : spNan[g];
    assign snan[g] = isDouble ? dpSnan[g] : spSnan[g];
    assign zero[g] = isDouble ? dpZero[g] : spZero[g];
  end

  logic [3:0] nzcvNext;
  logic       invRaise;
  logic       aLess;

  always_comb begin
    invRaise = sigMode ? (|nan) : (|snan);
    aLess    = (words[0] < words[1]) ^ sgn[0];
    if (|nan)
      nzcvNext = NZCV_UNORD;
    else if ((words[0] == words[1]) || (&zero))
      nzcvNext = NZCV_EQ;
    else if (sgn[0] != sgn[1])
      nzcvNext = sgn[0] ? NZCV_LT : NZCV_GT;
    else
      nzcvNext = aLess ? NZCV_LT : NZCV_GT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      status <= '0;
    end else begin
      if (strobes.loadFlags) flags <= nzcvNext;
      if (strobes.writeStat)
        status <= statWrData;
      else if (strobes.mergeStat)
        status <= {nzcvNext, status[SW-5:1], status[0] | invRaise};
    end
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isDouble,
  input  logic        sigMode,
  input  logic        cmpZero,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        statWrEn,
  input  logic [31:0] statWrData,
  output logic        outValid,
  output logic [3:0]  flags,
  output logic        invalidOp,
  output logic [31:0] status
);
  fcmpStrobes_t strobes;

  fcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .statWrEn(statWrEn),
    .strobes(strobes), .outValid(outValid));

  fcmp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isDouble(isDouble),
    .sigMode(sigMode), .cmpZero(cmpZero), .opA(opA), .opB(opB),
    .statWrData(statWrData), .flags(flags), .status(status));

  assign invalidOp = status[0];
endmodule

// File: rtl/fcmp_checker.sv
module fcmp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        statWrEn,
  input logic [31:0] statWrData,
  input logic        outValid,
  input logic [3:0]  flags,
  input logic        invalidOp,
  input logic [31:0] status
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(flags));
  p_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flags inside {4'b0011, 4'b0110, 4'b1000, 4'b0010}));
  p_merge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !statWrEn) |=> (status[31:28] == flags));
  p_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    !statWrEn |=> (status[27:1] == $past(status[27:1])));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !statWrEn) |=> status[0]);
  p_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    statWrEn |=> (status == $past(statWrData)));
  p_mirror_r2: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp == status[0]);
endmodule

bind fcmp_flag_unit fcmp_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .statWrEn(statWrEn),
  .statWrData(statWrData), .outValid(outValid), .flags(flags),
  .invalidOp(invalidOp), .status(status));

// File: tb/sim_fcmp_flag_unit.sv
module sim_fcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, isDouble = 1'b0, sigMode = 1'b0, cmpZero = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        statWrEn = 1'b0;
  logic [31:0] statWrData = '0;
  logic        outValid, invalidOp;
  logic [3:0]  flags;
  logic [31:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fcmp_flag_unit u0 (.*);

  localparam logic [3:0] UN = 4'b0011, EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010;
  localparam logic [63:0] S1 = 64'h3F800000, S2 = 64'h40000000;
  localparam logic [63:0] SM1 = 64'hBF800000, SM2 = 64'hC0000000;
  localparam logic [63:0] SNZ = 64'h80000000, SQN = 64'h7FC00000;
  localparam logic [63:0] SSN = 64'h7F800001, SINF = 64'h7F800000;
  localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
  localparam logic [63:0] DM2 = 64'hC000000000000000, DQN = 64'h7FF8000000000000;
  localparam logic [63:0] DSN = 64'h7FF0000000000001;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One compare: drive at negedge, sample at the following negedge.
  task automatic cmp(string req, logic [63:0] a, logic [63:0] b, logic dbl,
                     logic sig, logic z, logic [3:0] expF, logic expInv);
    @(negedge clk);
    opA = a; opB = b; isDouble = dbl; sigMode = sig; cmpZero = z; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " outValid"}, {63'b0, outValid}, 64'd1);
    chk({req, " flags"}, {60'b0, flags}, {60'b0, expF});
    chk({req, " invalidOp"}, {63'b0, invalidOp}, {63'b0, expInv});
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    statWrEn = 1'b1; statWrData = d;
    @(negedge clk);
    statWrEn = 1'b0;
    chk("R9 write", {32'b0, status}, {32'b0, d});
  endtask

  task automatic t_reset();
    chk("R11 status", {32'b0, status}, 64'd0);
    chk("R11 flags", {60'b0, flags}, 64'd0);
    chk("R11 outValid", {63'b0, outValid}, 64'd0);
  endtask

  task automatic t_order();
    cmp("R5 1<2", S1, S2, 0, 0, 0, LT, 0);
    cmp("R5 2>1", S2, S1, 0, 0, 0, GT, 0);
    cmp("R5 -1>-2", SM1, SM2, 0, 0, 0, GT, 0);
    cmp("R5 -2<-1", SM2, SM1, 0, 0, 0, LT, 0);
    cmp("R4 -1<1", SM1, S1, 0, 0, 0, LT, 0);
    cmp("R4 1>-1", S1, SM1, 0, 0, 0, GT, 0);
    cmp("R5 dbl 1<2", D1, D2, 1, 0, 0, LT, 0);
    cmp("R4 dbl -2<1", DM2, D1, 1, 0, 0, LT, 0);
  endtask

  task automatic t_equal();
    cmp("R3 1==1", S1, S1, 0, 0, 0, EQ, 0);
    cmp("R3 +0==-0", 64'd0, SNZ, 0, 0, 0, EQ, 0);
    cmp("R3 -0==+0", SNZ, 64'd0, 0, 0, 0, EQ, 0);
  endtask

  task automatic t_nan();
    cmp("R1 qnan quiet", SQN, S1, 0, 0, 0, UN, 0);
    cmp("R1 inf not nan", SINF, S1, 0, 0, 0, GT, 0);
    cmp("R2 snan quiet", S1, SSN, 0, 0, 0, UN, 1);
    cmp("R2 sticky", S1, S2, 0, 0, 0, LT, 1);
    wr(32'h0);
    cmp("R2 qnan signalling", S1, SQN, 0, 1, 0, UN, 1);
    wr(32'h0);
    cmp("R1 dbl qnan", DQN, D1, 1, 0, 0, UN, 0);
    cmp("R2 dbl snan", D1, DSN, 1, 0, 0, UN, 1);
    wr(32'h0);
  endtask

  task automatic t_ignored();
    cmp("R7 upper junk", {32'hFFFFFFFF, S1[31:0]}, S1, 0, 0, 0, EQ, 0);
    cmp("R7 upper nan", {32'h7FF80000, S1[31:0]}, {32'h12345678, S2[31:0]}, 0, 0, 0, LT, 0);
    cmp("R6 -1 vs 0", SM1, S2, 0, 0, 1, LT, 0);
    cmp("R6 +0 vs 0", 64'd0, S1, 0, 0, 1, EQ, 0);
    cmp("R6 inf vs 0", SINF, SM2, 0, 0, 1, GT, 0);
    cmp("R6 dbl 1 vs 0", D1, DM2, 1, 0, 1, GT, 0);
  endtask

  task automatic t_status();
    wr(32'hF5555554);
    cmp("R8 merge", S1, S2, 0, 0, 0, LT, 0);
    chk("R8 status", {32'b0, status}, 64'h85555554);
    cmp("R8 merge inv", S1, SSN, 0, 0, 0, UN, 1);
    chk("R8 status inv", {32'b0, status}, 64'h35555555);
    // write and compare in the same cycle: write wins, flags still update
    @(negedge clk);
    opA = S2; opB = S1; isDouble = 0; sigMode = 0; cmpZero = 0;
    inValid = 1'b1; statWrEn = 1'b1; statWrData = 32'h12345670;
    @(negedge clk);
    inValid = 1'b0; statWrEn = 1'b0;
    chk("R9 write wins", {32'b0, status}, 64'h12345670);
    chk("R9 flags updated", {60'b0, flags}, {60'b0, GT});
    // pulse and hold
    @(negedge clk);
    chk("R10 pulse ends", {63'b0, outValid}, 64'd0);
    chk("R10 flags held", {60'b0, flags}, {60'b0, GT});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_equal();
    t_nan();
    t_ignored();
    t_status();
    finish_run();
  end
endmodule